// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Slave

This block models a small two-wire serial EEPROM as seen by a host that bit-bangs the clock and data lines through a register. The host does not run a continuous bus. Instead it presents an update event carrying new clock and data levels. The slave classifies each event by comparing it with the clock and data levels it latched on the previous event. From that comparison it recognises start and stop conditions and valid rising clock edges.

After a start, eight bits form a command byte, whose least significant bit selects read (1) or write (0). The slave acknowledges it, and eight more bits form a word address. On the last address bit the addressed byte is fetched into a data shift register, and a further acknowledge is armed. The byte is shifted out, most significant bit first, during the address phase of the next transaction when that transaction carries a read command.

Storage is a read-only preload describing a memory module. Its depth is set by a parameter to 256 or 128 bytes. The level the slave drives is the latched data level, which the host reads back.

Top module: `bitbang_eeprom`

## Requirements
- R1: After reset the returned data level `sda_rd` is 1 and the slave is idle, with no acknowledge pending.
- R2: An update with clock high before and after, in which data falls, is a start. It restarts bit counting at the first command bit and clears the command byte, even in the middle of a transaction.
- R3: An update with clock high before and after, in which data rises, is a stop. It captures no bit and leaves the bit count unchanged.
- R4: While idle (no start seen since the last completed address phase, no acknowledge pending), rising clock edges capture nothing, and `sda_rd` follows the host's data level.
- R5: A bit is captured only on an update where the clock goes from low to high and data equals its latched level. A rising edge with changed data is not counted.
- R6: After the eighth command bit an acknowledge is armed. The next rising clock edge returns `sda_rd` = 0 and disarms it.
- R7: In read mode (command bit 0 = 1), each of the eight address-phase rising edges returns the top bit of the data shift register, which then shifts left by one. The byte therefore leaves MSB first.
- R8: On the eighth address bit the data register loads the byte at the captured address, an acknowledge is armed, and the slave returns to idle.
- R9: Preloaded content: bytes 0..7 are 80,08,04,0D,0A,01,40,00 (hex), byte 7E is 64, byte 7F is F4, and all other bytes are 00.
- R10: With DEPTH = 128 only the low 7 address bits select the byte, so addresses 80..FF return the same bytes as 00..7F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_en | input | 1 | Update event strobe, one cycle per host write |
| upd_scl | input | 1 | Clock level written by the host |
| upd_sda | input | 1 | Data level written by the host |
| sda_rd | output | 1 | Latched data level returned to the host |

## Verification
The bench builds two instances side by side, one with DEPTH = 256 and one with DEPTH = 128, and drives both from the same update stream. Every address from 00 to FF is read back from both instances. This covers the whole preload of the large store and, on the small one, every wrapped address above 7F. Start, stop and glitched clock edges are placed inside the command phase, where a miscounted bit shows up as an early or late acknowledge.

// File: rtl/bbe_pkg.sv
package bbe_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic stable;
  } bus_ev_t;

  // fixed module-descriptor preload
  function automatic logic [BYTE_W-1:0] preload_byte(input int idx);
    case (idx)
      0:   return 8'h80;
      1:   return 8'h08;
      2:   return 8'h04;
      3:   return 8'h0D;
      4:   return 8'h0A;
      5:   return 8'h01;
      6:   return 8'h40;
      126: return 8'h64;
      127: return 8'hF4;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/bbe_cond_decode.sv
module bbe_cond_decode
  import bbe_pkg::*;
(
  input  logic    scl_q,
  input  logic    sda_q,
  input  logic    scl_n,
  input  logic    sda_n,
  output bus_ev_t ev
);
  logic both_high;
  assign both_high = scl_q & scl_n;

  always_comb begin
    ev.start  = both_high & sda_q & ~sda_n;
    ev.stop   = both_high & ~sda_q & sda_n;
    ev.rise   = ~scl_q & scl_n;
    ev.stable = (sda_q == sda_n);
  end
endmodule

// File: rtl/bbe_rom.sv
module bbe_rom
  import bbe_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic [AW-1:0]     addr,
  output logic [BYTE_W-1:0] data
);
  logic [BYTE_W-1:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign tbl[g] = preload_byte(g);
  end

  assign data = tbl[addr];
endmodule

// File: rtl/bitbang_eeprom.sv
module bitbang_eeprom
  import bbe_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic upd_en,
  input  logic upd_scl,
  input  logic upd_sda,
  output logic sda_rd
);
  localparam int AW      = $clog2(DEPTH);
  localparam int CMD_END = BYTE_W + 1;
  localparam int ADR_END = 2 * BYTE_W + 1;
  localparam int CW      = $clog2(ADR_END + 1);
  localparam logic [CW-1:0] C_CMD_END = CW'(CMD_END);
  localparam logic [CW-1:0] C_ADR_END = CW'(ADR_END);
  localparam logic [CW-1:0] C_ONE     = CW'(1);

  logic [CW-1:0]     cnt_q, cnt_n;
  logic              ack_q, ack_n;
  logic [BYTE_W-1:0] cmd_q, cmd_n;
  logic [BYTE_W-1:0] adr_q, adr_n;
  logic [BYTE_W-1:0] dat_q, dat_n;
  logic              scl_q, scl_n;
  logic              sda_q, sda_n;
  logic              drv;
  logic [BYTE_W-1:0] rom_dat;
  bus_ev_t           ev;

  bbe_cond_decode u_dec (
    .scl_q (scl_q),
    .sda_q (sda_q),
    .scl_n (upd_scl),
    .sda_n (upd_sda),
    .ev    (ev)
  );

  bbe_rom #(.DEPTH(DEPTH)) u_rom (
    .addr (adr_n[AW-1:0]),
    .data (rom_dat)
  );

  always_comb begin
    cnt_n = cnt_q;
    ack_n = ack_q;
    cmd_n = cmd_q;
    adr_n = adr_q;
    dat_n = dat_q;
    scl_n = scl_q;
    sda_n = sda_q;
    drv   = upd_sda;
    if (upd_en) begin
      if (ev.start || ev.stop) begin
        if (ev.start) begin
          cnt_n = C_ONE;
          cmd_n = '0;
        end
      end else if (cnt_q == '0 && !ack_q) begin
        // idle: wait for a start
      end else if (ev.rise) begin
        if (ack_q) begin
          drv   = 1'b0;
          ack_n = 1'b0;
        end else if (ev.stable) begin
          if (cnt_q < C_CMD_END) begin
            cmd_n = {cmd_q[BYTE_W-2:0], upd_sda};
            cnt_n = cnt_q + C_ONE;
            if (cnt_n == C_CMD_END) ack_n = 1'b1;
          end else if (cnt_q < C_ADR_END) begin
            if (cmd_q[0]) drv = dat_q[BYTE_W-1];
            adr_n = {adr_q[BYTE_W-2:0], upd_sda};
            dat_n = {dat_q[BYTE_W-2:0], 1'b0};
            if (cnt_q + C_ONE == C_ADR_END) begin
              dat_n = rom_dat;
              ack_n = 1'b1;
              cnt_n = '0;
            end else begin
              cnt_n = cnt_q + C_ONE;
            end
          end else begin
            drv = 1'b0;
          end
        end
      end
      scl_n = upd_scl;
      sda_n = drv;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ack_q <= 1'b0;
      cmd_q <= '0;
      adr_q <= '0;
      dat_q <= '0;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      cnt_q <= cnt_n;
      ack_q <= ack_n;
      cmd_q <= cmd_n;
      adr_q <= adr_n;
      dat_q <= dat_n;
      scl_q <= scl_n;
      sda_q <= sda_n;
    end
  end

  assign sda_rd = sda_q;

  // counter never reaches the address-phase end value
  assert_cnt_range_R8: assert property (@(posedge clk) disable iff (rst)
    cnt_q < C_ADR_END);

  assert_start_restart_R2: assert property (@(posedge clk) disable iff (rst)
    upd_en && scl_q && upd_scl && sda_q && !upd_sda |=> cnt_q == C_ONE && cmd_q == '0);

  assert_ack_low_R6: assert property (@(posedge clk) disable iff (rst)
    upd_en && ack_q && !scl_q && upd_scl |=> !sda_rd && !ack_q);

  assert_idle_follow_R4: assert property (@(posedge clk) disable iff (rst)
    upd_en && cnt_q == '0 && !ack_q && !(scl_q && upd_scl && sda_q && !upd_sda)
    |=> cnt_q == '0 && sda_rd == $past(upd_sda));

  assert_glitch_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    upd_en && !ack_q && cnt_q != '0 && !scl_q && upd_scl && (upd_sda != sda_q)
    |=> $stable(cnt_q));

  assert_stop_nocount_R3: assert property (@(posedge clk) disable iff (rst)
    upd_en && scl_q && upd_scl && !sda_q && upd_sda |=> $stable(cnt_q));

  assert_hold_no_event_R4: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(sda_rd) && $stable(cnt_q));
endmodule

// File: tb/bitbang_eeprom_tb_top.sv
module bitbang_eeprom_tb_top;
  localparam int CLK_PER = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic upd_en = 1'b0;
  logic upd_scl = 1'b1;
  logic upd_sda = 1'b1;
  logic sda_a, sda_b;
  int checks = 0;
  int errors = 0;

  always #(CLK_PER/2) clk = ~clk;

  bitbang_eeprom #(.DEPTH(256)) dut_i (
    .clk(clk), .rst(rst), .upd_en(upd_en),
    .upd_scl(upd_scl), .upd_sda(upd_sda), .sda_rd(sda_a));

  bitbang_eeprom #(.DEPTH(128)) dut_small_i (
    .clk(clk), .rst(rst), .upd_en(upd_en),
    .upd_scl(upd_scl), .upd_sda(upd_sda), .sda_rd(sda_b));

  function automatic logic [7:0] exp_byte(input int a);
    case (a)
      0: return 8'h80; 1: return 8'h08; 2: return 8'h04; 3: return 8'h0D;
      4: return 8'h0A; 5: return 8'h01; 6: return 8'h40;
      126: return 8'h64; 127: return 8'hF4;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic upd(input logic s, input logic d);
    @(negedge clk);
    upd_en = 1'b1; upd_scl = s; upd_sda = d;
    @(negedge clk);
    upd_en = 1'b0;
  endtask

  task automatic bitw(input logic b);
    upd(1'b0, b); upd(1'b1, b);
  endtask

  task automatic start_c;
    upd(1'b0, 1'b1); upd(1'b1, 1'b1); upd(1'b1, 1'b0);
  endtask

  task automatic stop_c;
    upd(1'b0, 1'b0); upd(1'b1, 1'b0); upd(1'b1, 1'b1);
  endtask

  task automatic ack_c(input string req);
    upd(1'b0, 1'b1); upd(1'b1, 1'b1);
    chk({7'd0, sda_a}, 8'd0, req);
    chk({7'd0, sda_b}, 8'd0, req);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) bitw(v[i]);
  endtask

  task automatic set_addr(input logic [7:0] a);
    start_c; send_byte(8'hA0); ack_c("R6"); send_byte(a); ack_c("R8"); stop_c;
  endtask

  task automatic read_byte(input logic [7:0] nxt, output logic [7:0] ga, output logic [7:0] gb);
    start_c; send_byte(8'hA1); ack_c("R6");
    for (int i = 7; i >= 0; i--) begin
      bitw(nxt[i]);
      ga[i] = sda_a; gb[i] = sda_b;
    end
    ack_c("R8");
    stop_c;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] ga, gb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({7'd0, sda_a}, 8'd1, "R1");
    chk({7'd0, sda_b}, 8'd1, "R1");

    // R4: idle rises capture nothing, output follows host
    for (int i = 0; i < 12; i++) begin
      bitw(i[0]);
      chk({7'd0, sda_a}, {7'd0, i[0]}, "R4");
    end

    // R5: glitched rise inside command phase not counted
    upd(1'b0, 1'b1); upd(1'b1, 1'b1);
    start_c;
    for (int i = 0; i < 7; i++) bitw(1'b0);
    upd(1'b0, 1'b0); upd(1'b1, 1'b1);
    chk({7'd0, sda_a}, 8'd1, "R5");
    bitw(1'b1);
    chk({7'd0, sda_a}, 8'd1, "R5");
    ack_c("R5");
    send_byte(8'h05); ack_c("R8");
    // R8: idle after address ack
    upd(1'b0, 1'b1); upd(1'b1, 1'b1);
    chk({7'd0, sda_a}, 8'd1, "R8");
    bitw(1'b1);
    chk({7'd0, sda_a}, 8'd1, "R8");

    // R3: stop in the middle of a command does not count
    start_c;
    bitw(1'b1); bitw(1'b0); bitw(1'b0);
    upd(1'b1, 1'b1);
    for (int i = 0; i < 5; i++) bitw(1'b1);
    chk({7'd0, sda_a}, 8'd1, "R3");
    ack_c("R3");
    send_byte(8'h00); ack_c("R8"); stop_c;

    // R2: repeated start mid-command restarts counting
    start_c;
    for (int i = 0; i < 4; i++) bitw(1'b1);
    upd(1'b1, 1'b0);
    for (int i = 0; i < 8; i++) begin
      bitw(1'b1);
      chk({7'd0, sda_a}, 8'd1, "R2");
    end
    ack_c("R2");
    send_byte(8'h02); ack_c("R8"); stop_c;

    // R7/R9: read addr 2 (set above)
    read_byte(8'h03, ga, gb);
    chk(ga, exp_byte(2), "R7");
    chk(gb, exp_byte(2), "R7");

    // R9/R10: full sweep, sequential address driven during reads
    set_addr(8'h00);
    for (int k = 0; k < 256; k++) begin
      read_byte(8'((k + 1) % 256), ga, gb);
      chk(ga, exp_byte(k), "R9");
      chk(gb, exp_byte(k % 128), "R10");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule